// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins a controller-side open-drain data line to a card-side open-drain data line when neither side has a direction pin. While the link is open, whichever side pulls its line low first is treated as the source. The block then pulls the opposite side low and holds it there until the source side lets its line rise again. After that release the lane returns to a neutral state and waits for the next falling edge. Three identical lanes serve the main data line and two auxiliary lines.

Both sampled line levels pass through a synchronizer before edge detection. The block drives only pull-down enables; the pull-ups and the buffers sit outside it.

Link behaviour follows the power sequencer. While reception is disabled, the card-side lines are pulled low. When the sequencer enables reception, the card-side lines are released. A low chip select isolates the controller side: the controller lines are left to their weak pull-ups and nothing crosses in either direction. Controller-side levels change every microsecond at most (1 MHz), so a clock of a few MHz or more keeps the synchronizer latency well inside one bit.

Top module: `io_dir_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, every card-side pull-down enable is 1 and every controller-side pull-down enable is 0.
- R2: When reception-enable is 0, the next clock edge sets every card-side pull-down to 1 and every controller-side pull-down to 0. This overrides any drive in progress, and the lane returns to neutral.
- R3: With reception enabled, chip select high and no falling edge seen, both pull-downs of a lane are 0. A controller-side pull-down can only switch on in the cycle after one in which reception-enable and chip select were both 1.
- R4: In neutral, a falling edge on a card-side line makes the card the source. The controller-side pull-down of that lane switches on at the third rising clock edge after the level change, because of two synchronizer stages plus one output register. It switches on no earlier than that.
- R5: In neutral, a falling edge on a controller-side line makes the controller the source. The card-side pull-down of that lane switches on, with the same latency as in R4.
- R6: Once the source side's line rises, the drive on the other side is released and the lane returns to neutral. A line that is already low when neutral is re-entered does not start a new transfer.
- R7: If both sides of a lane fall in the same sample, the card side wins. The controller-side pull-down switches on and the card-side pull-down stays off.
- R8: With reception enabled and chip select at 0, both pull-downs of every lane are 0 on the next edge, any drive in progress is dropped, and falling edges are ignored.
- R9: Lanes are independent. Bit i of each line and pull-down port belongs to lane i: bit 0 is the main data line, bits 1 and 2 are the auxiliary lines.
- R10: A lane never enables both of its pull-downs at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Reception enable from the activation sequencer |
| cs_i | input | 1 | Chip select, active high |
| host_lvl_i | input | NUM_LANES | Sampled levels of the controller-side lines |
| card_lvl_i | input | NUM_LANES | Sampled levels of the card-side lines |
| host_pull_o | output | NUM_LANES | Pull-down enables for the controller-side lines |
| card_pull_o | output | NUM_LANES | Pull-down enables for the card-side lines |

## Verification
The assertions check four things on every cycle:
- no lane ever enables both of its pull-downs;
- reception off forces the card side low on the next edge;
- chip select low with reception on leaves all pull-downs off;
- a controller-side drive only starts when the link was open in the cycle before.

The bench scenarios are needed for the rest. They show which side wins a race, including a tie. They show the exact three-edge latency of a transfer. They show release on the source side's rising edge, the case where a still-low line is ignored after a release, and lanes running independently of each other.

// File: rtl/io_dir_arbiter_pkg.sv
package io_dir_arbiter_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_HOST = 2'd1,
        DIR_CARD = 2'd2
    } dir_e;

    typedef struct packed {
        dir_e dir;
        logic host_pull;
        logic card_pull;
        logic last_host;
        logic last_card;
    } lane_state_t;

    localparam lane_state_t LANE_RESET = '{
        dir:       DIR_IDLE,
        host_pull: 1'b0,
        card_pull: 1'b1,
        last_host: 1'b1,
        last_card: 1'b1
    };

endpackage

// File: rtl/io_dir_sync.sv
module io_dir_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/io_dir_lane.sv
module io_dir_lane
    import io_dir_arbiter_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_en_i,
    input  logic cs_i,
    input  logic host_s_i,
    input  logic card_s_i,
    output logic host_pull_o,
    output logic card_pull_o
);
    lane_state_t st_d, st_q;
    logic host_fall, host_rise, card_fall, card_rise;

    always_comb begin
        host_fall = st_q.last_host & ~host_s_i;
        host_rise = ~st_q.last_host & host_s_i;
        card_fall = st_q.last_card & ~card_s_i;
        card_rise = ~st_q.last_card & card_s_i;

        st_d           = st_q;
        st_d.last_host = host_s_i;
        st_d.last_card = card_s_i;

        if (!rx_en_i) begin
            st_d.dir       = DIR_IDLE;
            st_d.host_pull = 1'b0;
            st_d.card_pull = 1'b1;
        end else if (!cs_i) begin
            st_d.dir       = DIR_IDLE;
            st_d.host_pull = 1'b0;
            st_d.card_pull = 1'b0;
        end else begin
            unique case (st_q.dir)
                DIR_IDLE: begin
                    st_d.host_pull = 1'b0;
                    st_d.card_pull = 1'b0;
                    if (card_fall) begin
                        st_d.dir       = DIR_CARD;
                        st_d.host_pull = 1'b1;
                    end else if (host_fall) begin
                        st_d.dir       = DIR_HOST;
                        st_d.card_pull = 1'b1;
                    end
                end
                DIR_CARD: begin
                    if (card_rise) begin
                        st_d.dir       = DIR_IDLE;
                        st_d.host_pull = 1'b0;
                    end
                end
                DIR_HOST: begin
                    if (host_rise) begin
                        st_d.dir       = DIR_IDLE;
                        st_d.card_pull = 1'b0;
                    end
                end
                default: begin
                    st_d.dir       = DIR_IDLE;
                    st_d.host_pull = 1'b0;
                    st_d.card_pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= LANE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_pull_o = st_q.host_pull;
    assign card_pull_o = st_q.card_pull;
endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter #(
    parameter int NUM_LANES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_en_i,
    input  logic                 cs_i,
    input  logic [NUM_LANES-1:0] host_lvl_i,
    input  logic [NUM_LANES-1:0] card_lvl_i,
    output logic [NUM_LANES-1:0] host_pull_o,
    output logic [NUM_LANES-1:0] card_pull_o
);
    logic [NUM_LANES-1:0] host_s, card_s;

    io_dir_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync_host (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(host_lvl_i),
        .sync_o (host_s)
    );

    io_dir_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync_card (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(card_lvl_i),
        .sync_o (card_s)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        io_dir_lane u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .rx_en_i    (rx_en_i),
            .cs_i       (cs_i),
            .host_s_i   (host_s[i]),
            .card_s_i   (card_s[i]),
            .host_pull_o(host_pull_o[i]),
            .card_pull_o(card_pull_o[i])
        );
    end
endmodule

// File: rtl/io_dir_arbiter_chk.sv
module io_dir_arbiter_chk #(
    parameter int NUM_LANES = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 rx_en_i,
    input logic                 cs_i,
    input logic [NUM_LANES-1:0] host_pull_o,
    input logic [NUM_LANES-1:0] card_pull_o
);
    // R2: reception off pulls every card-side line low on the next edge
    p_rx_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_en_i |=> (card_pull_o == '1 && host_pull_o == '0));

    // R8: chip select low isolates both sides
    p_cs_iso_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_en_i && !cs_i) |=> (card_pull_o == '0 && host_pull_o == '0));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_chk
        // R10: never both pull-downs on one lane
        p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(host_pull_o[i] && card_pull_o[i]));

        // R3: controller-side drive starts only with the link open
        p_link_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(host_pull_o[i]) |-> $past(rx_en_i && cs_i));
    end
endmodule

bind io_dir_arbiter io_dir_arbiter_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en_i),
    .cs_i       (cs_i),
    .host_pull_o(host_pull_o),
    .card_pull_o(card_pull_o)
);

// File: tb/io_dir_arbiter_tb.sv
module io_dir_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       cs = 1'b1;
    logic [2:0] host_lvl = 3'b111;
    logic [2:0] card_lvl = 3'b111;
    logic [2:0] host_pull, card_pull;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    io_dir_arbiter u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rx_en_i    (rx_en),
        .cs_i       (cs),
        .host_lvl_i (host_lvl),
        .card_lvl_i (card_lvl),
        .host_pull_o(host_pull),
        .card_pull_o(card_pull)
    );

    // {rx_en, cs, host_lvl, card_lvl, exp host_pull, exp card_pull, req}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b1, 3'b111, 3'b111, 3'b000, 3'b111, 4'd2}, // R2 link closed
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd3}, // R3 open, idle
        {1'b1, 1'b1, 3'b111, 3'b110, 3'b001, 3'b000, 4'd4}, // R4 card lane0 falls
        {1'b1, 1'b1, 3'b110, 3'b110, 3'b001, 3'b000, 4'd4}, // R4 host follows
        {1'b1, 1'b1, 3'b110, 3'b111, 3'b000, 3'b000, 4'd6}, // R6 card releases
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd6}, // R6 still-low host ignored
        {1'b1, 1'b1, 3'b101, 3'b111, 3'b000, 3'b010, 4'd5}, // R5 host lane1 falls
        {1'b1, 1'b1, 3'b111, 3'b101, 3'b000, 3'b000, 4'd6}, // R6 host releases
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd3}, // R3 idle again
        {1'b1, 1'b1, 3'b011, 3'b011, 3'b100, 3'b000, 4'd7}, // R7 tie on lane2
        {1'b1, 1'b1, 3'b011, 3'b111, 3'b000, 3'b000, 4'd6}, // R6 card releases
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd3}, // R3 idle
        {1'b1, 1'b1, 3'b110, 3'b101, 3'b010, 3'b001, 4'd9}, // R9 opposite winners
        {1'b1, 1'b0, 3'b110, 3'b101, 3'b000, 3'b000, 4'd8}, // R8 cs drops drive
        {1'b1, 1'b0, 3'b110, 3'b001, 3'b000, 3'b000, 4'd8}, // R8 fall ignored
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd8}, // R8 nothing stale
        {1'b1, 1'b1, 3'b111, 3'b110, 3'b001, 3'b000, 4'd4}, // R4 card lane0 again
        {1'b0, 1'b1, 3'b111, 3'b110, 3'b000, 3'b111, 4'd2}, // R2 override
        {1'b1, 1'b1, 3'b111, 3'b111, 3'b000, 3'b000, 4'd3}  // R3 reopen
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 card pull in reset", card_pull, 3'b111);
        check("R1 host pull in reset", host_pull, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 card pull after reset", card_pull, 3'b111);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rx_en    = VEC[v][17];
            cs       = VEC[v][16];
            host_lvl = VEC[v][15:13];
            card_lvl = VEC[v][12:10];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec%0d host_pull", VEC[v][3:0], v), host_pull, VEC[v][9:7]);
            check($sformatf("R%0d vec%0d card_pull", VEC[v][3:0], v), card_pull, VEC[v][6:4]);
        end

        // R4: exact latency of a card-side fall
        repeat (4) @(posedge clk);
        @(negedge clk);
        card_lvl = 3'b011;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4 no drive before third edge", host_pull, 3'b000);
        @(posedge clk);
        @(negedge clk);
        check("R4 drive at third edge", host_pull, 3'b100);

        // R2: reception off overrides within one edge
        rx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 card pull one edge after rx off", card_pull, 3'b111);
        check("R2 host pull one edge after rx off", host_pull, 3'b000);

        finish_run();
    end
endmodule